// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a parameterised datapath stage. It takes two operands, a carry input, a four-bit operation code and two serial fill bits, and it returns one registered result word and a registered carry. The top two code bits choose one of four result groups: arithmetic, bitwise logic, shift toward the least significant end, or shift toward the most significant end. The bottom two code bits pick the operation inside the arithmetic and logic groups.

All arithmetic comes from a single ripple-carry adder that computes A + Y + Cin. The second adder input Y is one of four values: B, the ones' complement of B, all zeros or all ones. Together with the carry input, this one adder gives add, add-with-carry, subtract, subtract-with-borrow, increment, decrement and transfer. The result and carry are captured by an output register when the enable input is high. A synchronous reset clears that register.

Top module: `alsu_unit`

## Requirements
- R1: The operation code bits sel[3:2] choose the result group: 0 arithmetic, 1 logic, 2 shift right, 3 shift left.
- R2: In the arithmetic group, the result is (opa + Y + cin) mod 2^WIDTH. Y is opb when sel[1:0]=0, ~opb when 1, all zeros when 2 and all ones when 3. cout is the carry out of the top adder bit.
- R3: The arithmetic codes behave as the named operations. Code 0001 with cin=1 gives opa-opb, with cout=1 exactly when opa>=opb. Code 0010 with cin=1 increments, and all ones wraps to zero with cout=1. Code 0011 with cin=0 decrements, and zero wraps to all ones with cout=0. Code 0011 with cin=1 passes opa through with cout=1.
- R4: In the logic group, sel[1:0]=0 gives opa AND opb, 1 gives opa OR opb, 2 gives opa XOR opb, and 3 gives ~opa.
- R5: cin has no effect on the result in the logic and shift groups.
- R6: In shift right, result bit i equals opa bit i+1, and the top bit is taken from ser_r. sel[1:0] has no effect.
- R7: In shift left, result bit i equals opa bit i-1, and bit 0 is taken from ser_l. sel[1:0] has no effect.
- R8: cout is 0 whenever the captured operation is outside the arithmetic group.
- R9: When en is low on a clock edge, res and cout keep their previous values.
- R10: When rst is high on a clock edge, res and cout become 0. This holds whatever the value of en.
- R11: An operation presented with en high appears on res and cout right after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Capture enable for the output register |
| opa | input | WIDTH | First operand A |
| opb | input | WIDTH | Second operand B |
| cin | input | 1 | Adder carry input |
| sel | input | 4 | Operation code: [3:2] group, [1:0] operation within the group |
| ser_r | input | 1 | Fill bit for the top position on shift right |
| ser_l | input | 1 | Fill bit for bit 0 on shift left |
| res | output | WIDTH | Registered result |
| cout | output | 1 | Registered carry out |

## Verification
The bench runs every operation code with both carry inputs, over operands that include zero, all ones, the sign bit alone, 0x7F, alternating patterns and random pairs. This is where a carry chain that stops early, or a Y selector with swapped codes, would show up as wrong sums or as a wrong wrap at all ones or zero.

Directed cases check the four corners of increment and decrement wrap, and subtraction with equal operands. That last case is where a missing +1 would leave cout low. Shift cases with each fill bit set catch swapped serial inputs and off-by-one bit ordering.

Further checks compare results for cin=0 and cin=1 outside the arithmetic group, and confirm that cout stays zero there. Others hold the register with the enable low while the inputs change, and assert reset together with the enable. A design that leaked the adder carry, or let the carry input steer the logic group, fails these checks.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

   typedef enum logic [1:0] {
      GRP_ARITH = 2'd0,
      GRP_LOGIC = 2'd1,
      GRP_SHR   = 2'd2,
      GRP_SHL   = 2'd3
   } alsu_grp_e;

   typedef enum logic [1:0] {
      YSEL_B    = 2'd0,
      YSEL_NB   = 2'd1,
      YSEL_ZERO = 2'd2,
      YSEL_ONES = 2'd3
   } alsu_ysel_e;

   typedef enum logic [1:0] {
      LOP_AND  = 2'd0,
      LOP_OR   = 2'd1,
      LOP_XOR  = 2'd2,
      LOP_NOTA = 2'd3
   } alsu_lop_e;

endpackage

// File: rtl/alsu_fa.sv
module alsu_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   logic p;
   assign p  = a ^ b;
   assign s  = p ^ ci;
   assign co = (a & b) | (ci & p);
endmodule

// File: rtl/alsu_arith.sv
module alsu_arith
   import alsu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  alsu_ysel_e       ysel,
   output logic [WIDTH-1:0] d,
   output logic             cout
);
   localparam int NCARRY = WIDTH + 1;

   logic [NCARRY-1:0] carry;
   assign carry[0] = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic y_bit;
      always_comb begin
         unique case (ysel)
            YSEL_B:    y_bit = b[i];
            YSEL_NB:   y_bit = ~b[i];
            YSEL_ZERO: y_bit = 1'b0;
            default:   y_bit = 1'b1;
         endcase
      end
      alsu_fa u_fa (
         .a  (a[i]),
         .b  (y_bit),
         .ci (carry[i]),
         .s  (d[i]),
         .co (carry[i+1])
      );
   end

   assign cout = carry[NCARRY-1];
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
   import alsu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  alsu_lop_e        lop,
   output logic [WIDTH-1:0] e
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (lop)
            LOP_AND: e[i] = a[i] & b[i];
            LOP_OR:  e[i] = a[i] | b[i];
            LOP_XOR: e[i] = a[i] ^ b[i];
            default: e[i] = ~a[i];
         endcase
      end
   end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic             fill_r,
   input  logic             fill_l,
   output logic [WIDTH-1:0] to_lsb,
   output logic [WIDTH-1:0] to_msb
);
   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == TOP) begin : g_top
         assign to_lsb[i] = fill_r;
      end else begin : g_mid_r
         assign to_lsb[i] = a[i+1];
      end
      if (i == 0) begin : g_bot
         assign to_msb[i] = fill_l;
      end else begin : g_mid_l
         assign to_msb[i] = a[i-1];
      end
   end
endmodule

// File: rtl/alsu_unit.sv
module alsu_unit
   import alsu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   input  logic [3:0]       sel,
   input  logic             ser_r,
   input  logic             ser_l,
   output logic [WIDTH-1:0] res,
   output logic             cout
);
   if (WIDTH < 2) begin : g_bad_width
      $error("alsu_unit: WIDTH must be at least 2");
   end

   alsu_grp_e        grp;
   logic [WIDTH-1:0] d_arith;
   logic             c_arith;
   logic [WIDTH-1:0] e_logic;
   logic [WIDTH-1:0] h_right;
   logic [WIDTH-1:0] h_left;
   logic [WIDTH-1:0] f_next;
   logic             c_next;
   logic [WIDTH-1:0] res_q;
   logic             cout_q;

   assign grp = alsu_grp_e'(sel[3:2]);

   alsu_arith #(.WIDTH(WIDTH)) u_arith (
      .a    (opa),
      .b    (opb),
      .cin  (cin),
      .ysel (alsu_ysel_e'(sel[1:0])),
      .d    (d_arith),
      .cout (c_arith)
   );

   alsu_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (opa),
      .b   (opb),
      .lop (alsu_lop_e'(sel[1:0])),
      .e   (e_logic)
   );

   alsu_shift #(.WIDTH(WIDTH)) u_shift (
      .a      (opa),
      .fill_r (ser_r),
      .fill_l (ser_l),
      .to_lsb (h_right),
      .to_msb (h_left)
   );

   always_comb begin
      c_next = 1'b0;
      unique case (grp)
         GRP_ARITH: begin
            f_next = d_arith;
            c_next = c_arith;
         end
         GRP_LOGIC: f_next = e_logic;
         GRP_SHR:   f_next = h_right;
         default:   f_next = h_left;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q  <= '0;
         cout_q <= 1'b0;
      end else if (en) begin
         res_q  <= f_next;
         cout_q <= c_next;
      end
   end

   assign res  = res_q;
   assign cout = cout_q;
endmodule

// File: rtl/alsu_unit_chk.sv
module alsu_unit_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             cin,
   input logic [3:0]       sel,
   input logic             ser_r,
   input logic             ser_l,
   input logic [WIDTH-1:0] res,
   input logic             cout
);
   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= rst;

   // R10: the edge after a reset edge shows a cleared register
   always_ff @(posedge clk) begin
      if (rst_seen === 1'b1) begin
         p_reset_clears_r10: assert (res == '0 && cout == 1'b0)
            else $error("reset did not clear the output register");
      end
   end

   // R9
   p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(en)) |-> ($stable(res) && $stable(cout)));

   // R8
   p_no_carry_outside_arith_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en) && $past(sel[3:2]) != 2'b00) |-> (cout == 1'b0));

   // R4
   p_logic_and_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en) && $past(sel) == 4'b0100) |-> (res == ($past(opa) & $past(opb))));

   // R4
   p_logic_not_a_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en) && $past(sel) == 4'b0111) |-> (res == ~$past(opa)));

   // R6
   p_shift_right_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en) && $past(sel[3:2]) == 2'b10) |->
      (res[WIDTH-2:0] == $past(opa[WIDTH-1:1]) && res[WIDTH-1] == $past(ser_r)));

   // R7
   p_shift_left_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en) && $past(sel[3:2]) == 2'b11) |->
      (res[WIDTH-1:1] == $past(opa[WIDTH-2:0]) && res[0] == $past(ser_l)));

   // R3: code 0011 with the carry set passes A with a carry out
   p_transfer_carry_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en) && $past(sel) == 4'b0011 && $past(cin)) |->
      (res == $past(opa) && cout == 1'b1));
endmodule

bind alsu_unit alsu_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .en    (en),
   .opa   (opa),
   .opb   (opb),
   .cin   (cin),
   .sel   (sel),
   .ser_r (ser_r),
   .ser_l (ser_l),
   .res   (res),
   .cout  (cout)
);

// File: tb/alsu_unit_test.sv
module alsu_unit_test;
   localparam int W      = 8;
   localparam int TCLK   = 10;
   localparam int WDOG   = 150000;
   localparam int NCORN  = 7;
   localparam int NRAND  = 40;

   logic         clk = 1'b0;
   logic         rst;
   logic         en;
   logic [W-1:0] opa;
   logic [W-1:0] opb;
   logic         cin;
   logic [3:0]   sel;
   logic         ser_r;
   logic         ser_l;
   logic [W-1:0] res;
   logic         cout;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(TCLK/2) clk = ~clk;

   alsu_unit #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .en(en), .opa(opa), .opb(opb), .cin(cin),
      .sel(sel), .ser_r(ser_r), .ser_l(ser_l), .res(res), .cout(cout)
   );

   function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic c, input logic [3:0] s,
                                        input logic sr, input logic sl);
      logic [W-1:0] y;
      case (s[3:2])
         2'd0: begin
            case (s[1:0])
               2'd0: y = b;
               2'd1: y = ~b;
               2'd2: y = '0;
               default: y = '1;
            endcase
            return {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c};
         end
         2'd1: begin
            case (s[1:0])
               2'd0: return {1'b0, a & b};
               2'd1: return {1'b0, a | b};
               2'd2: return {1'b0, a ^ b};
               default: return {1'b0, ~a};
            endcase
         end
         2'd2: return {1'b0, sr, a[W-1:1]};
         default: return {1'b0, a[W-2:0], sl};
      endcase
   endfunction

   task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got cout=%0b res=%h, expected cout=%0b res=%h",
                  tag, got[W], got[W-1:0], exp[W], exp[W-1:0]);
      end
   endtask

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                        input logic [3:0] s, input logic sr, input logic sl);
      @(negedge clk);
      opa = a; opb = b; cin = c; sel = s; ser_r = sr; ser_l = sl; en = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_vec(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic c, input logic [3:0] s, input logic sr, input logic sl);
      drive(a, b, c, s, sr, sl);
      check(tag, {cout, res}, model(a, b, c, s, sr, sl));
   endtask

   function automatic logic [W-1:0] corner(input int k);
      case (k)
         0: return '0;
         1: return '1;
         2: return {1'b1, {(W-1){1'b0}}};
         3: return {1'b0, {(W-1){1'b1}}};
         4: return {{(W-1){1'b0}}, 1'b1};
         5: return {(W/2){2'b01}};
         default: return {(W/2){2'b10}};
      endcase
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [W:0] keep;
      rst = 1'b1; en = 1'b0; opa = '0; opb = '0; cin = 1'b0; sel = '0;
      ser_r = 1'b0; ser_l = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 reset state", {cout, res}, '0);
      rst = 1'b0;

      // R1 R2 R4 R6 R7: every code, both carries, corner operand pairs
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < NCORN; i++) begin
               for (int j = 0; j < NCORN; j++) begin
                  run_vec(s < 4 ? "R1 R2 arith" : s < 8 ? "R1 R4 logic" :
                          s < 12 ? "R1 R6 shr" : "R1 R7 shl",
                          corner(i), corner(j), c[0], s[3:0], i[0], j[0]);
               end
            end
            for (int r = 0; r < NRAND; r++) begin
               run_vec("R1 R2 random", W'($urandom), W'($urandom), c[0], s[3:0],
                       r[0], r[1]);
            end
         end
      end

      // R3 named operations
      drive(8'd5, 8'd3, 1'b1, 4'b0001, 1'b0, 1'b0);
      check("R3 subtract 5-3", {cout, res}, {1'b1, 8'd2});
      drive(8'd3, 8'd5, 1'b1, 4'b0001, 1'b0, 1'b0);
      check("R3 subtract 3-5 borrow", {cout, res}, {1'b0, 8'hFE});
      drive(8'h42, 8'h42, 1'b1, 4'b0001, 1'b0, 1'b0);
      check("R3 subtract equal", {cout, res}, {1'b1, 8'h00});
      drive(8'hFF, 8'h00, 1'b1, 4'b0010, 1'b0, 1'b0);
      check("R3 increment wrap", {cout, res}, {1'b1, 8'h00});
      drive(8'h00, 8'h00, 1'b0, 4'b0011, 1'b0, 1'b0);
      check("R3 decrement wrap", {cout, res}, {1'b0, 8'hFF});
      drive(8'h9C, 8'h11, 1'b1, 4'b0011, 1'b0, 1'b0);
      check("R3 transfer with carry", {cout, res}, {1'b1, 8'h9C});

      // R5: carry input ignored outside arithmetic
      for (int s = 4; s < 16; s++) begin
         drive(8'hB6, 8'h5D, 1'b0, s[3:0], 1'b1, 1'b1);
         keep = {cout, res};
         drive(8'hB6, 8'h5D, 1'b1, s[3:0], 1'b1, 1'b1);
         check("R5 cin ignored", {cout, res}, keep);
      end

      // R8: carry-producing operands with a non-arithmetic code
      drive(8'hFF, 8'hFF, 1'b1, 4'b0101, 1'b1, 1'b1);
      check("R8 cout zero in logic", {cout, 8'h00}, {1'b0, 8'h00});
      drive(8'hFF, 8'hFF, 1'b1, 4'b1100, 1'b1, 1'b1);
      check("R8 cout zero in shl", {cout, 8'h00}, {1'b0, 8'h00});

      // R11: new value only after the capturing edge
      drive(8'hFF, 8'h01, 1'b0, 4'b0000, 1'b0, 1'b0);
      @(negedge clk);
      opa = 8'h10; opb = 8'h20; cin = 1'b0; sel = 4'b0000; en = 1'b1;
      #1;
      check("R11 before edge", {cout, res}, {1'b1, 8'h00});
      @(posedge clk); #1;
      check("R11 after edge", {cout, res}, {1'b0, 8'h30});

      // R9: enable low holds despite input changes
      @(negedge clk);
      en = 1'b0; opa = 8'hAA; opb = 8'h0F; sel = 4'b0110; cin = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 hold", {cout, res}, {1'b0, 8'h30});

      // R10: reset wins over enable
      drive(8'hFF, 8'h01, 1'b0, 4'b0000, 1'b0, 1'b0);
      @(negedge clk);
      rst = 1'b1; en = 1'b1; sel = 4'b0000; opa = 8'h7F; opb = 8'h7F;
      @(negedge clk);
      check("R10 reset over enable", {cout, res}, '0);
      rst = 1'b0; en = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule